// File: doc/BRIEF.md
# YUV Video Input Capture Port

This block takes a digital component video stream from an external decoder and turns it into a uniform stream of full pixels. Each pixel carries 8-bit Y, U and V values. Data is taken only on clock edges where the clock-qualifier input is high. A line's active region comes from one of two places: the level of a horizontal reference input, or, in the embedded mode, the timing codes carried in the luma stream. Samples outside the active region never reach the output.

A static mode input selects one of four formats:

- **4:4:4** on three parallel buses.
- **4:2:2** with U and V alternating on one chroma bus.
- **4:1:1** with chroma spread two bits at a time over four samples.
- **4:2:2 with embedded timing codes.**

Chroma is collected per group. Every pixel of the group receives the same U/V pair, and the group's pixels leave on consecutive cycles. Three one-cycle flags mark the stream:

- a start-of-line flag on the first pixel of a line;
- an end-of-line strobe after the last pixel;
- an error pulse when a line ends inside an unfinished chroma group.

An optional stage limits values to the studio range.

Top module: `yuv_capture_port`

## Requirements
- R1: A sample is taken only on a rising clock edge where `cref_i` is high. Cycles with `cref_i` low change no state, whatever the values of `href_i` and the data buses.
- R2: In the external-reference modes (0, 1, 2), a qualified sample with `href_i` high that follows one with `href_i` low is pixel 0 of a line. Qualified samples with `href_i` low are discarded. `sol_o` is high together with `pix_valid_o` on the first pixel output of each line, and only there.
- R3: After every line, `eol_o` pulses for one cycle. The pulse comes only once all of that line's pixels have left, and never in a cycle with `pix_valid_o` high.
- R4: Mode 0 (4:4:4): `y_i`, `c_i` and `v_i` carry Y, U and V of the same pixel. The pixel is valid on the output in the cycle after the second rising edge following its capture.
- R5: Mode 1 (4:2:2): `c_i` carries U on even active samples and V on odd ones, counted from 0 at the line start. Pixels 2k and 2k+1 both get U from sample 2k and V from sample 2k+1. They are output on consecutive cycles, starting the cycle after the second edge following capture of sample 2k+1.
- R6: Mode 2 (4:1:1): within a group of four active samples numbered p = 0..3:
  - `c_i[7:6]` carries U bits [7-2p : 6-2p];
  - `c_i[5:4]` carries V bits [7-2p : 6-2p];
  - `c_i[3:0]` is ignored.

  All four pixels of the group get the same U and V.
- R7: Mode 3 (embedded codes):
  - Chroma is carried as in R5, and `href_i` is ignored.
  - A timing code is three qualified luma samples FF, 00, 00 followed by a status word with bit 7 set. Status bit 4 = 0 opens the active region after the code; bit 4 = 1 closes it before the FF.
  - The four code samples are never output as pixels.
  - Pixel order matches R5, delayed by four qualified samples.
- R8: When a line closes with an unfinished chroma group (an odd count in modes 1 and 3, a count that is not a multiple of four in mode 2), that group is dropped and `err_o` pulses for one cycle.
- R9: With `clip_en_i` high, output Y is limited to 16..235 and U and V to 16..240. With it low, values pass through unchanged.
- R10: While `rst_ni` is low, all flags are low and the chroma phase is cleared. The first line after reset begins with U.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Video sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Format: 0 = 4:4:4, 1 = 4:2:2, 2 = 4:1:1, 3 = 4:2:2 with embedded codes |
| clip_en_i | input | 1 | Enables studio-range limiting |
| cref_i | input | 1 | Clock qualifier; a sample is taken only while high |
| href_i | input | 1 | Active-line reference level (modes 0 to 2) |
| y_i | input | 8 | Luma bus |
| c_i | input | 8 | U in 4:4:4, multiplexed chroma in the other modes |
| v_i | input | 8 | V in 4:4:4, unused otherwise |
| pix_valid_o | output | 1 | Output pixel valid |
| sol_o | output | 1 | First pixel of a line |
| eol_o | output | 1 | End-of-line strobe |
| err_o | output | 1 | Unfinished chroma group dropped |
| y_o | output | 8 | Output luma |
| u_o | output | 8 | Output U |
| v_o | output | 8 | Output V |

## Verification
The assertions check the following on every cycle:

- end-of-line never overlaps a valid pixel, and start-of-line always does;
- no state moves while the qualifier is low;
- the pixel queue stays within one group;
- a timing code never enters the delay line as active;
- the fixed 4:4:4 latency holds;
- limited outputs stay inside the studio range.

Only the bench's scenarios can show the rest: the correct pairing of U/V with the luma of each group in every mode, the exact positions of pixels around embedded codes, and the dropping of partial groups together with the error pulse. A chroma phase that starts with U after a mid-line reset also needs a scenario.

// File: rtl/yuv_cap_pkg.sv
package yuv_cap_pkg;
  typedef enum logic [1:0] {
    MODE_444     = 2'd0,
    MODE_422     = 2'd1,
    MODE_411     = 2'd2,
    MODE_422_EMB = 2'd3
  } cap_mode_e;
endpackage

// File: rtl/yuv_cap_front.sv
module yuv_cap_front
  import yuv_cap_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cap_mode_e     mode_i,
  input  logic          cref_i,
  input  logic          href_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] c_i,
  input  logic [DW-1:0] v_i,
  output logic          stb_o,
  output logic          act_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] c_o,
  output logic [DW-1:0] v_o
);
  localparam int DEPTH = 4;
  localparam logic [DW-1:0] ALL1 = '1;
  localparam logic [DW-1:0] ALL0 = '0;

  logic [DW-1:0]    ly_q [DEPTH];
  logic [DW-1:0]    lc_q [DEPTH];
  logic [DEPTH-1:0] la_q;
  logic             win_q;
  logic             emb, code_hit, h_bit;

  assign emb      = (mode_i == MODE_422_EMB);
  assign code_hit = emb && (ly_q[2] == ALL1) && (ly_q[1] == ALL0) &&
                    (ly_q[0] == ALL0) && y_i[DW-1];
  assign h_bit    = y_i[DW-4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        ly_q[i] <= '0;
        lc_q[i] <= '0;
      end
      la_q  <= '0;
      win_q <= 1'b0;
    end else begin
      if (cref_i) begin
        for (int i = DEPTH-1; i > 0; i--) begin
          ly_q[i] <= ly_q[i-1];
          lc_q[i] <= lc_q[i-1];
          // an end code retracts the preamble already queued
          la_q[i] <= la_q[i-1] && !(code_hit && h_bit);
        end
        ly_q[0] <= y_i;
        lc_q[0] <= c_i;
        la_q[0] <= emb && win_q && !code_hit;
        if (code_hit) win_q <= !h_bit;
      end
      if (!emb) win_q <= 1'b0;
    end
  end

  assign stb_o = cref_i;
  assign act_o = emb ? la_q[DEPTH-1] : href_i;
  assign y_o   = emb ? ly_q[DEPTH-1] : y_i;
  assign c_o   = emb ? lc_q[DEPTH-1] : c_i;
  assign v_o   = v_i;

  a_r7_code_not_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cref_i && code_hit) |=> !la_q[0]);
  a_r7_end_code_retracts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cref_i && code_hit && h_bit) |=> (la_q[DEPTH-1:1] == '0));
endmodule

// File: rtl/yuv_cap_asm.sv
module yuv_cap_asm
  import yuv_cap_pkg::*;
#(
  parameter int DW   = 8,
  parameter int GMAX = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cap_mode_e     mode_i,
  input  logic          stb_i,
  input  logic          act_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] c_i,
  input  logic [DW-1:0] v_i,
  output logic          pix_valid_o,
  output logic          sol_o,
  output logic          eol_o,
  output logic          err_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] u_o,
  output logic [DW-1:0] v_o
);
  localparam int PW = $clog2(GMAX);
  localparam int CK = DW / 4;

  logic          act_q, sol_pend_q, out_sol_q, eol_pend_q;
  logic [PW-1:0] phase_q, qidx_q, ph, last;
  logic [PW:0]   qcnt_q;
  logic [DW-1:0] acc_y [GMAX];
  logic [DW-1:0] out_y [GMAX];
  logic [DW-1:0] acc_u, acc_v, out_u, out_v, nu, nv;

  always_comb begin
    unique case (mode_i)
      MODE_444: last = '0;
      MODE_411: last = PW'(GMAX-1);
      default:  last = PW'(1);
    endcase
  end

  assign ph = act_q ? phase_q : '0;

  always_comb begin
    unique case (mode_i)
      MODE_444: begin nu = c_i;   nv = v_i; end
      MODE_411: begin
        nu = {acc_u[DW-CK-1:0], c_i[DW-1 -: CK]};
        nv = {acc_v[DW-CK-1:0], c_i[DW-CK-1 -: CK]};
      end
      default:  begin nu = acc_u; nv = c_i; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; phase_q <= '0; qidx_q <= '0; qcnt_q <= '0;
      sol_pend_q <= 1'b0; out_sol_q <= 1'b0; eol_pend_q <= 1'b0;
      acc_u <= '0; acc_v <= '0; out_u <= '0; out_v <= '0;
      for (int i = 0; i < GMAX; i++) begin
        acc_y[i] <= '0;
        out_y[i] <= '0;
      end
      pix_valid_o <= 1'b0; sol_o <= 1'b0; eol_o <= 1'b0; err_o <= 1'b0;
      y_o <= '0; u_o <= '0; v_o <= '0;
    end else begin
      pix_valid_o <= 1'b0;
      sol_o       <= 1'b0;
      eol_o       <= 1'b0;
      err_o       <= 1'b0;
      // drain the last completed group, then release a pending end of line
      if (qcnt_q != '0) begin
        pix_valid_o <= 1'b1;
        sol_o       <= out_sol_q && (qidx_q == '0);
        y_o         <= out_y[qidx_q];
        u_o         <= out_u;
        v_o         <= out_v;
        qidx_q      <= qidx_q + 1'b1;
        qcnt_q      <= qcnt_q - 1'b1;
      end else if (eol_pend_q) begin
        eol_o      <= 1'b1;
        eol_pend_q <= 1'b0;
      end
      if (stb_i) begin
        act_q <= act_i;
        if (act_i) begin
          if (!act_q) sol_pend_q <= 1'b1;
          acc_y[ph] <= y_i;
          if (mode_i == MODE_411) begin
            acc_u <= nu;
            acc_v <= nv;
          end else if (ph == '0) begin
            acc_u <= c_i;
          end
          if (ph == last) begin
            for (int i = 0; i < GMAX; i++)
              out_y[i] <= (PW'(i) == ph) ? y_i : acc_y[i];
            out_u      <= nu;
            out_v      <= nv;
            out_sol_q  <= !act_q || sol_pend_q;
            sol_pend_q <= 1'b0;
            qcnt_q     <= {1'b0, last} + 1'b1;
            qidx_q     <= '0;
            phase_q    <= '0;
          end else begin
            phase_q <= ph + 1'b1;
          end
        end else if (act_q) begin
          eol_pend_q <= 1'b1;
          if (phase_q != '0) err_o <= 1'b1;
          phase_q <= '0;
        end
      end
    end
  end

  a_r3_eol_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |-> !pix_valid_o);
  a_r2_sol_on_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_o |-> pix_valid_o);
  a_r1_hold_without_cref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> ($stable(phase_q) && $stable(act_q) && $stable(acc_u)));
  a_r4_fixed_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_444 && stb_i && act_i) |-> ##2 pix_valid_o);
  a_r8_err_at_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(stb_i && !act_i && act_q));
  a_r5_queue_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qcnt_q <= (PW+1)'(GMAX));
endmodule

// File: rtl/yuv_cap_limit.sv
module yuv_cap_limit #(
  parameter int DW = 8,
  parameter int LO = 16,
  parameter int HI = 235
) (
  input  logic          en_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] d_o
);
  localparam logic [DW-1:0] LO_V = DW'(LO);
  localparam logic [DW-1:0] HI_V = DW'(HI);

  always_comb begin
    if (en_i && d_i < LO_V)      d_o = LO_V;
    else if (en_i && d_i > HI_V) d_o = HI_V;
    else                         d_o = d_i;
  end
endmodule

// File: rtl/yuv_capture_port.sv
module yuv_capture_port
  import yuv_cap_pkg::*;
#(
  parameter int DW   = 8,
  parameter int GMAX = 4,
  parameter int Y_LO = 16,
  parameter int Y_HI = 235,
  parameter int C_LO = 16,
  parameter int C_HI = 240
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          clip_en_i,
  input  logic          cref_i,
  input  logic          href_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] c_i,
  input  logic [DW-1:0] v_i,
  output logic          pix_valid_o,
  output logic          sol_o,
  output logic          eol_o,
  output logic          err_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] u_o,
  output logic [DW-1:0] v_o
);
  cap_mode_e     mode;
  logic          f_stb, f_act;
  logic [DW-1:0] f_y, f_c, f_v;
  logic [DW-1:0] raw [3];
  logic [DW-1:0] lim [3];

  assign mode = cap_mode_e'(mode_i);

  yuv_cap_front #(.DW(DW)) u_front (
    .clk_i, .rst_ni, .mode_i(mode), .cref_i, .href_i, .y_i, .c_i, .v_i,
    .stb_o(f_stb), .act_o(f_act), .y_o(f_y), .c_o(f_c), .v_o(f_v)
  );

  yuv_cap_asm #(.DW(DW), .GMAX(GMAX)) u_asm (
    .clk_i, .rst_ni, .mode_i(mode), .stb_i(f_stb), .act_i(f_act),
    .y_i(f_y), .c_i(f_c), .v_i(f_v),
    .pix_valid_o, .sol_o, .eol_o, .err_o,
    .y_o(raw[0]), .u_o(raw[1]), .v_o(raw[2])
  );

  for (genvar g = 0; g < 3; g++) begin : g_lim
    yuv_cap_limit #(
      .DW(DW),
      .LO(g == 0 ? Y_LO : C_LO),
      .HI(g == 0 ? Y_HI : C_HI)
    ) u_lim (
      .en_i(clip_en_i), .d_i(raw[g]), .d_o(lim[g])
    );
  end

  assign y_o = lim[0];
  assign u_o = lim[1];
  assign v_o = lim[2];

  a_r9_clip_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clip_en_i && pix_valid_o) |->
      (y_o >= DW'(Y_LO) && y_o <= DW'(Y_HI) &&
       u_o >= DW'(C_LO) && u_o <= DW'(C_HI) &&
       v_o >= DW'(C_LO) && v_o <= DW'(C_HI)));
  a_r10_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !(pix_valid_o || eol_o || err_o || sol_o));
endmodule

// File: tb/tb_yuv_capture_port.sv
module tb_yuv_capture_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       clip_en, cref, href;
  logic [7:0] y_in, c_in, v_in;
  logic       pix_valid, sol, eol, err;
  logic [7:0] y_out, u_out, v_out;

  always #4 clk = ~clk;

  yuv_capture_port dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .clip_en_i(clip_en),
    .cref_i(cref), .href_i(href), .y_i(y_in), .c_i(c_in), .v_i(v_in),
    .pix_valid_o(pix_valid), .sol_o(sol), .eol_o(eol), .err_o(err),
    .y_o(y_out), .u_o(u_out), .v_o(v_out)
  );

  int          checks = 0, fails = 0, eol_seen = 0, err_seen = 0;
  logic [24:0] exp_q[$];
  logic [24:0] e;
  string       tag = "R10";
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string t, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, expv);
    end
  endtask

  task automatic summary();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic logic [7:0] lim(input logic [7:0] d, input logic [7:0] lo,
                                     input logic [7:0] hi, input bit en);
    if (!en) return d;
    if (d < lo) return lo;
    if (d > hi) return hi;
    return d;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pix_valid) begin
        if (exp_q.size() == 0) chk(1'b0, tag, "unexpected pixel", {y_out, u_out, v_out}, 0);
        else begin
          e = exp_q.pop_front();
          chk({y_out, u_out, v_out} == e[23:0], tag, "pixel", {y_out, u_out, v_out}, e[23:0]);
          chk(sol == e[24], "R2", "sol flag", sol, e[24]);
        end
      end
      if (eol) begin
        eol_seen++;
        chk(!pix_valid && exp_q.size() == 0, "R3", "eol after last pixel", exp_q.size(), 0);
      end
      if (err) err_seen++;
    end
  end

  task automatic put(input bit cr, input bit hr, input logic [7:0] yy,
                     input logic [7:0] cc, input logic [7:0] vv);
    @(negedge clk);
    cref = cr; href = hr; y_in = yy; c_in = cc; v_in = vv;
  endtask

  task automatic run_line(input int n, input bit gaps);
    int grp, nfull, p;
    bit emb;
    logic [7:0] ya[64], ua[64], va[64];
    logic [7:0] ug, vg, cm;
    emb   = (mode == 2'd3);
    grp   = (mode == 2'd0) ? 1 : (mode == 2'd2) ? 4 : 2;
    nfull = (n / grp) * grp;
    tag   = clip_en ? "R9" : (mode == 2'd0) ? "R4" : (mode == 2'd1) ? "R5" :
            (mode == 2'd2) ? "R6" : "R7";
    ug = '0; vg = '0;
    for (int k = 0; k < n; k++) begin
      if (k % grp == 0) begin ug = 8'($urandom); vg = 8'($urandom); end
      ya[k] = emb ? 8'(1 + $urandom % 254) : 8'($urandom);
      ua[k] = (mode == 2'd0) ? 8'($urandom) : ug;
      va[k] = (mode == 2'd0) ? 8'($urandom) : vg;
    end
    for (int k = 0; k < nfull; k++)
      exp_q.push_back({k == 0, lim(ya[k], 8'd16, 8'd235, clip_en),
                       lim(ua[k], 8'd16, 8'd240, clip_en),
                       lim(va[k], 8'd16, 8'd240, clip_en)});
    eol_seen = 0; err_seen = 0;
    repeat (3) put(1, 0, 8'h10, 8'h80, 8'h80);
    if (emb) begin
      put(1, 1'($urandom), 8'hFF, 8'hFF, 8'h00);
      put(1, 1'($urandom), 8'h00, 8'h00, 8'h00);
      put(1, 1'($urandom), 8'h00, 8'h00, 8'h00);
      put(1, 1'($urandom), 8'h80, 8'h80, 8'h00);  // start code
    end
    for (int k = 0; k < n; k++) begin
      if (gaps && $urandom % 3 == 0)  // R1: unqualified junk
        put(0, 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      p = k % 4;
      if (mode == 2'd0)      cm = ua[k];
      else if (mode == 2'd2) cm = {ua[k][6-2*p +: 2], va[k][6-2*p +: 2], 4'($urandom)};
      else                   cm = (k % 2 == 0) ? ua[k] : va[k];
      put(1, emb ? 1'($urandom) : 1'b1, ya[k], cm,
          (mode == 2'd0) ? va[k] : 8'($urandom));
    end
    if (emb) begin
      put(1, 1'($urandom), 8'hFF, 8'hFF, 8'h00);
      put(1, 1'($urandom), 8'h00, 8'h00, 8'h00);
      put(1, 1'($urandom), 8'h00, 8'h00, 8'h00);
      put(1, 1'($urandom), 8'h9D, 8'h9D, 8'h00);  // end code
    end
    repeat (6) put(1, 0, 8'h10, 8'h80, 8'h80);
    repeat (10) put(0, 0, 8'h00, 8'h00, 8'h00);
    chk(eol_seen == 1, "R3", "eol count", eol_seen, 1);
    chk(err_seen == ((n % grp != 0) ? 1 : 0), "R8", "err pulses", err_seen, (n % grp != 0));
    chk(exp_q.size() == 0, tag, "pixels left", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; mode = 2'd0; clip_en = 1'b0;
    cref = 1'b0; href = 1'b0; y_in = '0; c_in = '0; v_in = '0;
    repeat (3) @(negedge clk);
    chk(!pix_valid && !sol && !eol && !err, "R10", "reset flags", {pix_valid, sol, eol, err}, 0);
    chk(y_out == 0 && u_out == 0 && v_out == 0, "R10", "reset data", {y_out, u_out, v_out}, 0);
    rst_n = 1'b1;

    // R4 exact latency
    tag = "R4";
    exp_q.push_back({1'b1, 8'h55, 8'h66, 8'h77});
    eol_seen = 0;
    repeat (3) put(1, 0, 8'h10, 8'h80, 8'h80);
    put(1, 1, 8'h55, 8'h66, 8'h77);
    @(negedge clk); cref = 1'b0;
    chk(pix_valid == 0, "R4", "no output one edge after capture", pix_valid, 0);
    @(negedge clk);
    chk(pix_valid == 1 && y_out == 8'h55, "R4", "pixel two edges after capture", {pix_valid, y_out}, 9'h155);
    repeat (4) put(1, 0, 8'h10, 8'h80, 8'h80);
    repeat (6) put(0, 0, 8'h00, 8'h00, 8'h00);
    chk(eol_seen == 1, "R3", "eol after single pixel", eol_seen, 1);

    // directed corners per mode: full and partial groups, with clip extremes
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      clip_en = 1'b0; run_line(8, 1'b0);
      run_line(5, 1'b1);
      clip_en = 1'b1; run_line(12, 1'b1);
    end

    // R10: reset mid-line in 4:2:2, next line must start with U
    mode = 2'd1; clip_en = 1'b0;
    repeat (3) put(1, 0, 8'h10, 8'h80, 8'h80);
    put(1, 1, 8'h40, 8'hAA, 8'h00);
    @(negedge clk); rst_n = 1'b0; cref = 1'b0;
    @(negedge clk);
    chk(!pix_valid && !eol && !err, "R10", "flags held in reset", {pix_valid, eol, err}, 0);
    @(negedge clk); rst_n = 1'b1; href = 1'b0;
    exp_q.delete();
    tag = "R10";
    run_line(6, 1'b0);

    // constrained random
    for (int it = 0; it < 40; it++) begin
      mode    = 2'($urandom % 4);
      clip_en = 1'($urandom);
      run_line(1 + int'($urandom % 20), 1'($urandom));
    end
    summary();
  end
endmodule